// File: doc/BRIEF.md
# PWM Synchronization Pulse Generator

This block runs the period counter of a PWM unit and emits a synchronization pulse whose length is programmable. In single-update operation one pulse leaves per switching period, at the start of the period. In double-update operation a second pulse starts halfway through the period, so pulses come at twice the switching rate. A 10-bit width register sets the pulse length to its value plus one clock cycles. It comes out of reset holding its maximum value.

The counter can also be driven by an external sync pin. When external mode is on, a rising edge on that pin restarts the period at count zero. The pin can pass through a two-flop synchronizer when it is asynchronous to the clock, or it can be taken directly with a single edge register when it is already synchronous. If no edge arrives, the internal counter keeps running, so the pulses never stop. Downstream compare channels read the period count and the cycle-start strobe.

Top module: `pwm_sync_gen`

## Requirements
- R1: While reset is asserted, sync_o and cyc_start_o are 0 and count_o is 0. After reset the width register holds 0x3FF, so the first pulse lasts 1024 cycles.
- R2: count_o steps by one from 0 to P-1 (P = period_i, P >= 2) and then returns to 0. cyc_start_o is high exactly in the cycles where a period begins with count_o = 0.
- R3: With dbl_upd_i = 0, sync_o rises only at a period start.
- R4: With dbl_upd_i = 1, an extra pulse starts in the cycle where count_o equals floor(P/2).
- R5: A write with width_we_i = 1 loads width_wdata_i as W. Each pulse then stays high for W+1 cycles (1 to 1024).
- R6: A trigger that arrives while sync_o is high restarts the width count, so overlapping pulses merge into one continuous high level.
- R7: With ext_mode_i = 0, ext_sync_i has no effect on count_o or sync_o.
- R8: With ext_mode_i = 1 and ext_is_sync_i = 1, a rising level that is present before a clock edge makes count_o 0 and cyc_start_o 1 after that edge.
- R9: With ext_mode_i = 1 and ext_is_sync_i = 0, the restart becomes visible after the third clock edge that sees the new level.
- R10: Only a rising edge restarts the period. Holding the pin high gives a single restart. A restart in mid-period cuts that period short.
- R11: In external mode with no edges, the period continues from the internal counter.
- R12: A restart starts a fresh pulse of full width W+1, measured from the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Period length P in cycles |
| dbl_upd_i | input | 1 | Double-update mode enable |
| ext_mode_i | input | 1 | Follow the external sync pin |
| ext_is_sync_i | input | 1 | 1: pin is synchronous, 0: pass it through the synchronizer |
| width_we_i | input | 1 | Width register write enable |
| width_wdata_i | input | WID_W | Width register write data |
| ext_sync_i | input | 1 | External sync pin |
| sync_o | output | 1 | Synchronization pulse |
| count_o | output | CNT_W | Period counter |
| cyc_start_o | output | 1 | Period-start strobe |

## Verification
The bench builds the block with CNT_W = 12, WID_W = 10 and SYNC_STAGES = 2. A 12-bit counter allows a 2000-cycle period, so the full 1024-cycle default pulse can be seen ending inside one period. The same counter width also allows short periods, where double-update overlap and merged pulses occur. With two synchronizer stages the asynchronous restart latency is a fixed three edges, and the bench checks that exact cycle against the one-edge direct path.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int unsigned WIDTH_BITS = 10;

  typedef struct packed {
    logic start;
    logic mid;
  } pwm_trig_t;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pwm_ext_edge.sv
module pwm_ext_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic is_sync_i,
  output logic rise_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;
  logic            dir_q, dir_d;
  logic            rise_async, rise_dir;

  always_comb begin
    sh_d  = {sh_q[SH_W-2:0], ext_i};
    dir_d = ext_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      dir_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      dir_q <= dir_d;
    end
  end

  assign rise_async = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  assign rise_dir   = ext_i & ~dir_q;
  assign rise_o     = is_sync_i ? rise_dir : rise_async;

  // A synchronized level change yields one single-cycle edge.
  assert_async_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_async |=> !rise_async);
  // A direct edge is followed by the registered high level.
  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_dir |=> dir_q);
endmodule

// File: rtl/pwm_width_reg.sv
module pwm_width_reg #(
  parameter int unsigned WID_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WID_W-1:0] wdata_i,
  output logic [WID_W-1:0] width_o
);
  logic [WID_W-1:0] w_q, w_d;

  always_comb begin
    w_d = w_q;
    if (we_i) w_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w_q <= '1;
    else        w_q <= w_d;
  end

  assign width_o = w_q;

  assert_width_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_i) |-> $stable(w_q));
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             dbl_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output pwm_trig_t        trig_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, half;
  logic             first_q, first_d;
  logic             start_q, start_d;
  logic             mid_q, mid_d;
  logic             at_last;

  always_comb begin
    cnt_inc = cnt_q + ONE;
    half    = period_i >> 1;
    at_last = (cnt_q >= (period_i - ONE));
    cnt_d   = cnt_inc;
    first_d = 1'b0;
    start_d = 1'b0;
    mid_d   = 1'b0;
    if (restart_i || first_q || at_last) begin
      cnt_d   = '0;
      start_d = 1'b1;
    end else begin
      mid_d = dbl_i && (cnt_inc == half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      start_q <= 1'b0;
      mid_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
      start_q <= start_d;
      mid_q   <= mid_d;
    end
  end

  assign cnt_o        = cnt_q;
  assign trig_o.start = start_q;
  assign trig_o.mid   = mid_q;

  assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cnt_q == '0));
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + ONE));
  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (start_q && cnt_q == '0));
  assert_mid_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_q && $stable(period_i)) |-> (cnt_q == (period_i >> 1)));
  assert_mid_needs_dbl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mid_q |-> $past(dbl_i));
endmodule

// File: rtl/pwm_pulse_gen.sv
module pwm_pulse_gen
  import pwm_sync_pkg::*;
#(
  parameter int unsigned WID_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwm_trig_t        trig_i,
  input  logic [WID_W-1:0] width_i,
  output logic             pulse_o
);
  logic [WID_W-1:0] rem_q, rem_d;
  logic             busy_q, busy_d;
  logic             fire;

  always_comb begin
    fire   = trig_i.start | trig_i.mid;
    rem_d  = rem_q;
    busy_d = busy_q;
    if (fire) begin
      rem_d  = width_i;
      busy_d = (width_i != '0);
    end else if (busy_q) begin
      rem_d  = rem_q - 1'b1;
      busy_d = (rem_q != {{(WID_W-1){1'b0}}, 1'b1});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      busy_q <= busy_d;
    end
  end

  assign pulse_o = fire | busy_q;

  assert_busy_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(fire));
  assert_rem_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fire) |=> (fire || !busy_q || rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/pwm_sync_gen.sv
module pwm_sync_gen
  import pwm_sync_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned WID_W       = WIDTH_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             dbl_upd_i,
  input  logic             ext_mode_i,
  input  logic             ext_is_sync_i,
  input  logic             width_we_i,
  input  logic [WID_W-1:0] width_wdata_i,
  input  logic             ext_sync_i,
  output logic             sync_o,
  output logic [CNT_W-1:0] count_o,
  output logic             cyc_start_o
);
  logic             rst_s_n;
  logic             ext_rise;
  logic             restart;
  logic [WID_W-1:0] width;
  pwm_trig_t        trig;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  pwm_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_s_n), .ext_i(ext_sync_i),
    .is_sync_i(ext_is_sync_i), .rise_o(ext_rise));

  assign restart = ext_mode_i & ext_rise;

  pwm_width_reg #(.WID_W(WID_W)) u_wreg (
    .clk(clk), .rst_n(rst_s_n), .we_i(width_we_i),
    .wdata_i(width_wdata_i), .width_o(width));

  pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_s_n), .period_i(period_i), .dbl_i(dbl_upd_i),
    .restart_i(restart), .cnt_o(count_o), .trig_o(trig));

  pwm_pulse_gen #(.WID_W(WID_W)) u_pulse (
    .clk(clk), .rst_n(rst_s_n), .trig_i(trig), .width_i(width),
    .pulse_o(sync_o));

  assign cyc_start_o = trig.start;

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    cyc_start_o |-> sync_o);
endmodule

// File: tb/tb_pwm_sync_gen.sv
`timescale 1ns/1ps
module tb_pwm_sync_gen;
  localparam int CNT_W = 12;
  localparam int WID_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] period_i;
  logic             dbl_upd_i, ext_mode_i, ext_is_sync_i, width_we_i, ext_sync_i;
  logic [WID_W-1:0] width_wdata_i;
  logic             sync_o, cyc_start_o;
  logic [CNT_W-1:0] count_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwm_sync_gen #(.CNT_W(CNT_W), .WID_W(WID_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .dbl_upd_i(dbl_upd_i),
    .ext_mode_i(ext_mode_i), .ext_is_sync_i(ext_is_sync_i),
    .width_we_i(width_we_i), .width_wdata_i(width_wdata_i),
    .ext_sync_i(ext_sync_i), .sync_o(sync_o), .count_o(count_o),
    .cyc_start_o(cyc_start_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_width(input int w);
    width_we_i = 1'b1; width_wdata_i = WID_W'(w);
    step();
    width_we_i = 1'b0;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    step();
    while (!cyc_start_o && n < 5000) begin step(); n++; end
    chk(cyc_start_o, req, "period start seen", cyc_start_o, 1);
  endtask

  // Compare count_o / sync_o / cyc_start_o over n cycles from a start.
  task automatic run_pattern(input string req, input int p, input int n,
                             input int w, input bit dbl);
    int half = p / 2;
    for (int i = 0; i < n; i++) begin
      int ph = i % p;
      bit es = (ph <= w) || (dbl && ph >= half && ph <= half + w);
      chk(count_o == CNT_W'(ph), req, "count", count_o, ph);
      chk(sync_o == es, req, "sync", sync_o, es);
      chk(cyc_start_o == (ph == 0), req, "cyc_start", cyc_start_o, ph == 0);
      step();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    period_i = CNT_W'(2000);
    repeat (3) step();
    chk(!sync_o && !cyc_start_o && count_o == 0, "R1", "outputs in reset",
        {sync_o, cyc_start_o}, 0);
    rst_n = 1'b1;
    wait_start("R1");
    begin
      int hi = 0;
      while (sync_o && hi < 3000) begin hi++; step(); end
      // default 0x3FF gives 1024 cycles
      chk(hi == 1024, "R1", "default pulse length", hi, 1024);
    end
  endtask

  task automatic t_single();
    period_i = CNT_W'(50); dbl_upd_i = 1'b0;
    set_width(4);
    wait_start("R3");
    run_pattern("R3", 50, 120, 4, 1'b0);   // R2 R3 R5
  endtask

  task automatic t_width0();
    period_i = CNT_W'(20);
    set_width(0);
    wait_start("R5");
    run_pattern("R5", 20, 60, 0, 1'b0);
  endtask

  task automatic t_double();
    period_i = CNT_W'(50); dbl_upd_i = 1'b1;
    set_width(3);
    wait_start("R4");
    run_pattern("R4", 50, 100, 3, 1'b1);
    period_i = CNT_W'(51);
    wait_start("R4");
    run_pattern("R4", 51, 102, 3, 1'b1);   // odd period: mid at 25
  endtask

  task automatic t_retrig();
    period_i = CNT_W'(60); dbl_upd_i = 1'b1;
    set_width(35);
    wait_start("R6");
    for (int i = 0; i < 120; i++) begin
      chk(sync_o, "R6", "merged pulse stays high", sync_o, 1);
      step();
    end
    dbl_upd_i = 1'b0;
  endtask

  task automatic t_ext_off();
    ext_mode_i = 1'b0; ext_is_sync_i = 1'b1;
    period_i = CNT_W'(50);
    set_width(3);
    wait_start("R7");
    for (int i = 0; i < 100; i++) begin
      ext_sync_i = (i % 7 == 3);
      chk(count_o == CNT_W'(i % 50), "R7", "count ignores pin", count_o, i % 50);
      chk(sync_o == ((i % 50) <= 3), "R7", "sync ignores pin", sync_o, (i % 50) <= 3);
      step();
    end
    ext_sync_i = 1'b0;
    repeat (4) step();
  endtask

  task automatic t_ext_direct();
    ext_mode_i = 1'b1; ext_is_sync_i = 1'b1;
    set_width(19);
    wait_start("R8");
    repeat (10) step();
    chk(count_o == 10, "R10", "pre-restart count", count_o, 10);
    ext_sync_i = 1'b1;
    step();
    chk(count_o == 0 && cyc_start_o, "R8", "direct restart after one edge", count_o, 0);
    for (int j = 0; j < 61; j++) begin
      if (j == 30) ext_sync_i = 1'b0;
      chk(count_o == CNT_W'(j % 50), "R10", "held pin restarts once", count_o, j % 50);
      if (j < 25)
        chk(sync_o == (j < 20), "R12", "full width after restart", sync_o, j < 20);
      step();
    end
  endtask

  task automatic t_ext_async();
    ext_is_sync_i = 1'b0;
    set_width(3);
    wait_start("R9");
    repeat (20) step();
    ext_sync_i = 1'b1;
    step();
    chk(count_o == 21, "R9", "no restart after edge 1", count_o, 21);
    step();
    chk(count_o == 22, "R9", "no restart after edge 2", count_o, 22);
    step();
    chk(count_o == 0 && cyc_start_o && sync_o, "R9", "restart after edge 3", count_o, 0);
    ext_sync_i = 1'b0;
    step();
  endtask

  task automatic t_ext_quiet();
    ext_is_sync_i = 1'b1;
    wait_start("R11");
    run_pattern("R11", 50, 100, 3, 1'b0);
    ext_mode_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; period_i = '0; dbl_upd_i = 1'b0; ext_mode_i = 1'b0;
    ext_is_sync_i = 1'b1; width_we_i = 1'b0; width_wdata_i = '0; ext_sync_i = 1'b0;
    t_reset();
    t_single();
    t_width0();
    t_double();
    t_retrig();
    t_ext_off();
    t_ext_direct();
    t_ext_async();
    t_ext_quiet();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule